// File: doc/BRIEF.md
# Non-Power-of-Two Depth FIFO

A single-clock first-in first-out buffer whose capacity is 2^N − 2^M entries, for example twelve entries out of a sixteen-slot address space (N = 4, M = 2). The storage array holds exactly that many words, so none of the address space is wasted. The read and write pointers do not use a modulo compare to wrap. Each pointer is a plain binary counter, and only the bit of weight 2^M gets extra logic when the pointer wraps. A parameter selects the up-counting form or the down-counting form.

The producer writes a word by raising `push_en` with `push_data`. The consumer requests a word by raising `pop_en`. The data returns on `pop_data` one cycle later, marked by `pop_valid`. Flow control is plain level signalling and not a valid/ready handshake. The producer must treat `full` as back-pressure and hold its word while `full` is high, unless it pops in the same cycle. The consumer must treat `empty` the same way. A push into a full buffer, or a pop from an empty one, is dropped and recorded in a sticky error flag. The occupancy flags almost-full, almost-empty and half-full are computed against the reduced depth.

Top module: `npo2_fifo`

## Requirements
- R1: The capacity is 2^PTR_W − 2^GAP_W words (12 by default). `full` rises on the push that stores the last free word and not on any earlier push.
- R2: Words leave in the order they were accepted, with their values intact, over any number of pointer laps.
- R3: An accepted pop (`pop_en` high while `empty` is low) raises `pop_valid` for exactly the following cycle, with the word on `pop_data` in that same cycle. No other cycle raises `pop_valid`.
- R4: In up mode (`WRAP_MODE` = 0) a pointer runs from 2^GAP_W to 2^PTR_W − 1 and wraps back by forcing bit GAP_W to one. In down mode (`WRAP_MODE` = 1) a pointer runs from 2^PTR_W − 2^GAP_W − 1 down to 0 and wraps by clearing bit GAP_W. Both modes give identical port behaviour.
- R5: `empty` is high exactly when the occupancy is 0, and `full` is high exactly when the occupancy equals the capacity. The occupancy rises on a push-only cycle, falls on a pop-only cycle and holds when both are accepted.
- R6: `half_full` is high exactly when twice the occupancy is at least the capacity.
- R7: `almost_full` is high exactly when the occupancy is at least the capacity minus `AF_MARGIN`. `almost_empty` is high exactly when the occupancy is at most `AE_MARGIN`.
- R8: A push while full with no pop is dropped. The stored contents and the occupancy do not change, and `overflow` becomes 1 and stays 1. A pop while empty returns nothing, so `pop_valid` stays 0, and `underflow` becomes 1 and stays 1.
- R9: A push and a pop in the same cycle on a full buffer are both accepted. `full` stays high and the popped word is the oldest one.
- R10: A synchronous reset returns both pointers to their start value and the occupancy to 0. It raises `empty` and `almost_empty` and clears `full`, `almost_full`, `half_full`, `overflow`, `underflow` and `pop_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Write request |
| push_data | input | WIDTH | Word to store |
| pop_en | input | 1 | Read request |
| pop_data | output | WIDTH | Word returned by the previous accepted pop |
| pop_valid | output | 1 | `pop_data` carries a word this cycle |
| full | output | 1 | Occupancy equals capacity |
| empty | output | 1 | Occupancy is zero |
| almost_full | output | 1 | Occupancy at least capacity − AF_MARGIN |
| almost_empty | output | 1 | Occupancy at most AE_MARGIN |
| half_full | output | 1 | Twice the occupancy at least the capacity |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop hit an empty buffer |

## Verification
The bench drives both wrap modes side by side and runs long streams that take the pointers around the twelve-entry ring many times. A pointer that rolled over at sixteen instead of twelve would read stale or unwritten slots, and the scoreboard would report out-of-order words. The bench fills the buffer one word at a time and checks every flag at every occupancy, so a threshold taken from 2^N instead of the real capacity, or an off-by-one compare, shows up at the level where it flips. It also pushes into a full buffer, pops from an empty one, and pushes and pops together while full. A design that accepted the dropped word, emitted a phantom `pop_valid`, or refused the write that the pop made room for would lose or add data.

// File: rtl/npo2_fifo_pkg.sv
`timescale 1ns/1ps
package npo2_fifo_pkg;

  typedef enum logic {
    WRAP_UP   = 1'b0,
    WRAP_DOWN = 1'b1
  } wrap_mode_e;

  function automatic int npo2_depth(input int n, input int m);
    return (1 << n) - (1 << m);
  endfunction

endpackage

// File: rtl/npo2_fifo_ptr.sv
`timescale 1ns/1ps
module npo2_fifo_ptr
  import npo2_fifo_pkg::*;
#(
  parameter int         N    = 4,
  parameter int         M    = 2,
  parameter wrap_mode_e MODE = WRAP_UP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [N-1:0] ptr
);

  localparam int DEPTH = npo2_depth(N, M);
  localparam logic [N-1:0] TOP   = (MODE == WRAP_UP) ? N'((1 << N) - 1) : N'(DEPTH - 1);
  localparam logic [N-1:0] BOT   = (MODE == WRAP_UP) ? N'(1 << M) : N'(0);
  localparam logic [N-1:0] START = (MODE == WRAP_UP) ? BOT : TOP;
  localparam logic [N-1:0] LAST  = (MODE == WRAP_UP) ? TOP : BOT;

  logic [N:0]   step;
  logic [N-1:0] nxt;

  generate
    if (MODE == WRAP_UP) begin : g_up
      // carry out of the top bit re-inserts the 2^M offset
      always_comb begin
        step   = {1'b0, ptr} + 1'b1;
        nxt    = step[N-1:0];
        nxt[M] = step[M] | step[N];
      end
    end else begin : g_dn
      // borrow out of zero removes the 2^M gap from the all-ones value
      always_comb begin
        step   = {1'b0, ptr} - 1'b1;
        nxt    = step[N-1:0];
        nxt[M] = step[M] & ~step[N];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      ptr <= START;
    else if (adv) ptr <= nxt;
  end

  generate
    if (MODE == WRAP_UP) begin : g_up_chk
      a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ptr[N-1:M] != '0);
      a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
    end else begin : g_dn_chk
      a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= TOP);
      a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr != LAST) |=> ptr == $past(ptr) - 1'b1);
    end
  endgenerate

  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr == LAST) |=> ptr == START);

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/npo2_fifo_mem.sv
`timescale 1ns/1ps
module npo2_fifo_mem
  import npo2_fifo_pkg::*;
#(
  parameter int         W    = 8,
  parameter int         N    = 4,
  parameter int         M    = 2,
  parameter wrap_mode_e MODE = WRAP_UP
) (
  input  logic         clk,
  input  logic         we,
  input  logic [N-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic         re,
  input  logic [N-1:0] raddr,
  output logic [W-1:0] rdata
);

  localparam int DEPTH = npo2_depth(N, M);
  localparam int LO    = (MODE == WRAP_UP) ? (1 << M) : 0;
  localparam int HI    = LO + DEPTH - 1;

  // index range matches the pointer range, so no address translation
  logic [W-1:0] store [LO:HI];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/npo2_fifo_level.sv
`timescale 1ns/1ps
module npo2_fifo_level #(
  parameter int DEPTH     = 12,
  parameter int AF_MARGIN = 2,
  parameter int AE_MARGIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty,
  output logic almost_full,
  output logic almost_empty,
  output logic half_full
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (inc && !dec) count <= count + 1'b1;
    else if (dec && !inc) count <= count - 1'b1;
  end

  always_comb begin
    full         = int'(count) == DEPTH;
    empty        = count == '0;
    almost_full  = int'(count) >= DEPTH - AF_MARGIN;
    almost_empty = int'(count) <= AE_MARGIN;
    half_full    = 2 * int'(count) >= DEPTH;
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);
  a_r5_full_no_grow: assert property (@(posedge clk) disable iff (rst)
    full |-> !(inc && !dec));
  a_r5_empty_no_shrink: assert property (@(posedge clk) disable iff (rst)
    empty |-> !dec);
  a_r9_full_both_holds: assert property (@(posedge clk) disable iff (rst)
    (full && inc && dec) |=> full);

endmodule

// File: rtl/npo2_fifo.sv
`timescale 1ns/1ps
module npo2_fifo
  import npo2_fifo_pkg::*;
#(
  parameter int         WIDTH     = 8,
  parameter int         PTR_W     = 4,
  parameter int         GAP_W     = 2,
  parameter int         AF_MARGIN = 2,
  parameter int         AE_MARGIN = 2,
  parameter wrap_mode_e WRAP_MODE = WRAP_UP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic             full,
  output logic             empty,
  output logic             almost_full,
  output logic             almost_empty,
  output logic             half_full,
  output logic             overflow,
  output logic             underflow
);

  localparam int DEPTH = npo2_depth(PTR_W, GAP_W);

  logic             pop_ok;
  logic             push_ok;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // a pop on a full buffer frees the slot the same-cycle push needs
  assign pop_ok  = pop_en && !empty;
  assign push_ok = push_en && (!full || pop_ok);

  npo2_fifo_ptr #(.N(PTR_W), .M(GAP_W), .MODE(WRAP_MODE)) u_wr_ptr (
    .clk (clk),
    .rst (rst),
    .adv (push_ok),
    .ptr (wr_ptr)
  );

  npo2_fifo_ptr #(.N(PTR_W), .M(GAP_W), .MODE(WRAP_MODE)) u_rd_ptr (
    .clk (clk),
    .rst (rst),
    .adv (pop_ok),
    .ptr (rd_ptr)
  );

  npo2_fifo_mem #(.W(WIDTH), .N(PTR_W), .M(GAP_W), .MODE(WRAP_MODE)) u_mem (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wr_ptr),
    .wdata (push_data),
    .re    (pop_ok),
    .raddr (rd_ptr),
    .rdata (pop_data)
  );

  npo2_fifo_level #(.DEPTH(DEPTH), .AF_MARGIN(AF_MARGIN), .AE_MARGIN(AE_MARGIN)) u_level (
    .clk          (clk),
    .rst          (rst),
    .inc          (push_ok),
    .dec          (pop_ok),
    .full         (full),
    .empty        (empty),
    .almost_full  (almost_full),
    .almost_empty (almost_empty),
    .half_full    (half_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pop_valid <= pop_ok;
      if (push_en && !push_ok) overflow  <= 1'b1;
      if (pop_en && empty)     underflow <= 1'b1;
    end
  end

  a_r3_valid_after_pop: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ($past(pop_en) && !$past(empty)));
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (full && push_en && !pop_en) |=> (full && overflow));
  a_r8_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_en) |=> (!pop_valid && underflow));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

// File: tb/npo2_fifo_bench.sv
`timescale 1ns/1ps
module npo2_fifo_bench;
  import npo2_fifo_pkg::*;

  localparam int W     = 8;
  localparam int N     = 4;
  localparam int M     = 2;
  localparam int DEPTH = 12;
  localparam int AFM   = 2;
  localparam int AEM   = 2;

  logic clk = 1'b0;
  logic rst;
  logic push_en, pop_en;
  logic [W-1:0] push_data;

  logic [W-1:0] pd_up, pd_dn;
  logic pv_up, pv_dn, fu_up, fu_dn, em_up, em_dn, af_up, af_dn, ae_up, ae_dn;
  logic hf_up, hf_dn, ov_up, ov_dn, un_up, un_dn;

  always #2.5 clk = ~clk;

  npo2_fifo #(.WIDTH(W), .PTR_W(N), .GAP_W(M), .AF_MARGIN(AFM), .AE_MARGIN(AEM),
              .WRAP_MODE(WRAP_UP)) u_npo2_fifo (
    .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .pop_data(pd_up), .pop_valid(pv_up), .full(fu_up), .empty(em_up),
    .almost_full(af_up), .almost_empty(ae_up), .half_full(hf_up),
    .overflow(ov_up), .underflow(un_up));

  npo2_fifo #(.WIDTH(W), .PTR_W(N), .GAP_W(M), .AF_MARGIN(AFM), .AE_MARGIN(AEM),
              .WRAP_MODE(WRAP_DOWN)) u_npo2_fifo_dn (
    .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .pop_data(pd_dn), .pop_valid(pv_dn), .full(fu_dn), .empty(em_dn),
    .almost_full(af_dn), .almost_empty(ae_dn), .half_full(hf_dn),
    .overflow(ov_dn), .underflow(un_dn));

  int checks = 0;
  int fails = 0;
  int mcount = 0;
  bit movf = 0;
  bit munf = 0;
  int exp_pops = 0;
  int got_pops = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_status(input bit exp_pv);
    chk(pv_up == exp_pv, "R3 pop_valid", int'(pv_up), int'(exp_pv));
    chk(fu_up == (mcount == DEPTH), "R5 full", int'(fu_up), int'(mcount == DEPTH));
    chk(em_up == (mcount == 0), "R5 empty", int'(em_up), int'(mcount == 0));
    chk(hf_up == (2 * mcount >= DEPTH), "R6 half_full", int'(hf_up), int'(2 * mcount >= DEPTH));
    chk(af_up == (mcount >= DEPTH - AFM), "R7 almost_full", int'(af_up), int'(mcount >= DEPTH - AFM));
    chk(ae_up == (mcount <= AEM), "R7 almost_empty", int'(ae_up), int'(mcount <= AEM));
    chk(ov_up == movf, "R8 overflow", int'(ov_up), int'(movf));
    chk(un_up == munf, "R8 underflow", int'(un_up), int'(munf));
    chk({pv_dn, fu_dn, em_dn, hf_dn, af_dn, ae_dn, ov_dn, un_dn} ==
        {pv_up, fu_up, em_up, hf_up, af_up, ae_up, ov_up, un_up},
        "R4 down-mode flags", int'({pv_dn, fu_dn, em_dn, hf_dn, af_dn, ae_dn, ov_dn, un_dn}),
        int'({pv_up, fu_up, em_up, hf_up, af_up, ae_up, ov_up, un_up}));
  endtask

  // driver: applies one cycle of stimulus and updates the reference model
  task automatic step(input bit p, input bit r, input logic [W-1:0] d);
    bit pa, ra;
    push_en = p; pop_en = r; push_data = d;
    ra = r && (mcount > 0);
    pa = p && ((mcount < DEPTH) || ra);
    if (p && !pa) movf = 1;
    if (r && mcount == 0) munf = 1;
    if (pa) q.push_back(d);
    if (ra) exp_pops++;
    mcount = mcount + int'(pa) - int'(ra);
    @(posedge clk);
    #1;
    push_en = 0; pop_en = 0;
    check_status(ra);
  endtask

  task automatic do_reset();
    rst = 1; push_en = 0; pop_en = 0; push_data = '0;
    repeat (2) @(posedge clk);
    #1;
    rst = 0;
    mcount = 0; movf = 0; munf = 0;
    q.delete();
  endtask

  // monitor: scoreboard compare of returned words
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if (pv_up !== pv_dn) chk(0, "R4 pop_valid match", int'(pv_dn), int'(pv_up));
      if (pv_up === 1'b1) begin
        got_pops++;
        if (q.size() == 0) begin
          chk(0, "R8 phantom word", 1, 0);
        end else begin
          logic [W-1:0] e;
          e = q.pop_front();
          chk(pd_up == e, "R2 data order", int'(pd_up), int'(e));
          chk(pd_dn == e, "R4 down-mode data", int'(pd_dn), int'(e));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R10: state straight out of reset
    chk(em_up == 1 && ae_up == 1, "R10 empty after reset", int'({em_up, ae_up}), 3);
    chk({fu_up, af_up, hf_up, ov_up, un_up, pv_up} == 6'b0, "R10 flags clear",
        int'({fu_up, af_up, hf_up, ov_up, un_up, pv_up}), 0);
    check_status(0);

    // R8: pop on empty
    step(0, 1, '0);
    step(0, 0, '0);

    // R1: fill one word at a time
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, W'(8'h10 + i));
      chk(fu_up == (i == DEPTH - 1), "R1 full at capacity", int'(fu_up), int'(i == DEPTH - 1));
    end

    // R8: push while full is dropped
    step(1, 0, 8'hEE);
    step(1, 0, 8'hEF);

    // R9: push and pop together while full
    step(1, 1, 8'h50);
    chk(fu_up == 1, "R9 full held", int'(fu_up), 1);
    step(1, 1, 8'h51);
    chk(fu_up == 1, "R9 full held again", int'(fu_up), 1);

    // drain, then one more pop on empty
    while (mcount > 0) step(0, 1, '0);
    step(0, 1, '0);
    step(0, 0, '0);

    // R2/R4: long streams in three phases, many laps
    for (int c = 0; c < 1800; c++) begin
      bit p, r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c < 600)       begin p = (lfsr[1:0] != 2'b00); r = lfsr[2] & lfsr[3]; end
      else if (c < 1200) begin p = lfsr[2] & lfsr[3];    r = (lfsr[1:0] != 2'b00); end
      else               begin p = lfsr[4];              r = lfsr[5]; end
      step(p, r, lfsr[W+3:4]);
    end
    while (mcount > 0) step(0, 1, '0);
    step(0, 0, '0);

    // R10: reset with contents and sticky flags set
    for (int i = 0; i < 7; i++) step(1, 0, W'(8'hA0 + i));
    do_reset();
    chk(em_up == 1 && fu_up == 0, "R10 empty after mid reset", int'({em_up, fu_up}), 2);
    chk(ov_up == 0 && un_up == 0, "R10 sticky cleared", int'({ov_up, un_up}), 0);
    check_status(0);
    for (int i = 0; i < 3; i++) step(1, 0, W'(8'hC0 + i));
    for (int i = 0; i < 3; i++) step(0, 1, '0);
    step(0, 0, '0);
    step(0, 0, '0);

    chk(got_pops == exp_pops, "R3 pop count", got_pops, exp_pops);
    chk(q.size() == 0, "R2 nothing left", q.size(), 0);
    finish_run();
  end

endmodule